// File: doc/BRIEF.md
# Two-Button Saturating Step Controller

This block keeps a two-bit position that moves by exactly one step for each physical press of one of two push buttons. One button moves the position up and the other moves it down. Both buttons arrive raw: they are asynchronous to the system clock and their contacts bounce. The block conditions each button in its own chain before the state machine sees it. The chain is a two-stage synchronizer, then a debouncer, then a rising-edge detector. As a result, a press of any length gives a single one-cycle pulse.

The position saturates at both ends, so it never wraps. When both buttons produce a pulse in the same cycle, the up request takes priority. The system clock is nominally 50 MHz. The default debounce wait is 500,000 cycles, which is 10 ms at that clock, and it is held in a 19-bit counter. A synchronous active-high reset returns the whole block to its released, position-zero state.

Top module: `step_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pos` becomes 2'b00 and every conditioning register returns to the released (0) level. After reset, no step occurs until a button is pressed.
- R2: `pos` is the position in plain binary: position 0 is 00, 1 is 01, 2 is 10 and 3 is 11. An accepted up press at positions 0, 1 or 2 raises `pos` by one.
- R3: An accepted down press at positions 1, 2 or 3 lowers `pos` by one.
- R4: An up press at position 3 leaves `pos` at 11. A down press at position 0 leaves `pos` at 00. The position never wraps.
- R5: When the up pulse and the down pulse fall in the same cycle, the down pulse is discarded and the up pulse alone acts. The result is +1 below position 3 and no change at position 3.
- R6: A button held high for any number of cycles produces exactly one step.
- R7: A raw level that lasts fewer than `DEB_CYCLES` consecutive synchronized cycles is rejected and gives no step. A level that lasts at least `DEB_CYCLES` cycles is accepted.
- R8: Suppose a raw input rises and then stays high, and edge 1 is the first rising clock edge that samples it high. `pos` still holds its old value after edge `DEB_CYCLES`+2 and shows the new value after edge `DEB_CYCLES`+3.
- R9: Overlapping presses are each acted on. Take this sequence: up pressed, down pressed, up released, up pressed again, down released. It gives +1, -1, no change, +1, no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| up_btn | input | 1 | Raw asynchronous up button, high when pressed |
| dn_btn | input | 1 | Raw asynchronous down button, high when pressed |
| pos | output | 2 | Current position, binary 0 to 3 |

## Verification
The assertions assume that the press pulses come only from the debounced levels. They also assume that reset is held from time zero until the first edges have passed, so that every `$past` value is defined. The bench holds reset from time zero. It drives the raw buttons only at falling clock edges, so every level change is a clean synchronous step. It keeps each deliberate press or release for more than the debounce wait, and it keeps the glitch test one cycle shorter than that wait. Together these make each intended press land as exactly one pulse and each glitch land as none.

// File: rtl/step_ctrl.sv
module step_ctrl #(
  parameter int DEB_CYCLES = 500000,
  localparam int CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       up_btn,
  input  logic       dn_btn,
  output logic [1:0] pos
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_CYCLES - 1);

  logic [1:0] raw;
  logic [1:0] meta, sync, level, level_d, pulse;
  logic up_pulse, dn_pulse;

  assign raw = {dn_btn, up_btn};

  for (genvar b = 0; b < 2; b++) begin : g_btn
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        meta[b]    <= 1'b0;
        sync[b]    <= 1'b0;
        level[b]   <= 1'b0;
        level_d[b] <= 1'b0;
        cnt        <= '0;
      end else begin
        meta[b]    <= raw[b];
        sync[b]    <= meta[b];
        level_d[b] <= level[b];
        if (sync[b] == level[b]) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          level[b] <= sync[b];
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign pulse[b] = level[b] & ~level_d[b];
  end

  assign up_pulse = pulse[0];
  assign dn_pulse = pulse[1];

  always_ff @(posedge clk) begin
    if (rst)
      pos <= 2'd0;
    else if (up_pulse) begin
      if (pos != 2'd3) pos <= pos + 2'd1;
    end else if (dn_pulse) begin
      if (pos != 2'd0) pos <= pos - 2'd1;
    end
  end

endmodule

// File: rtl/step_ctrl_chk.sv
module step_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       up_pulse,
  input logic       dn_pulse,
  input logic [1:0] pos
);

  AST_RESET_POS: assert property (@(posedge clk) rst |=> pos == 2'd0); // R1
  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (up_pulse && pos != 2'd3) |=> pos == $past(pos) + 2'd1); // R2
  AST_DN_STEP: assert property (@(posedge clk) disable iff (rst)
    (dn_pulse && !up_pulse && pos != 2'd0) |=> pos == $past(pos) - 2'd1); // R3
  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
    pos == 2'd3 |=> pos != 2'd0); // R4
  AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (rst)
    pos == 2'd0 |=> pos != 2'd3); // R4
  AST_UP_WINS: assert property (@(posedge clk) disable iff (rst)
    (up_pulse && dn_pulse) |=> pos != $past(pos) - 2'd1 || $past(pos) == 2'd0); // R5
  AST_UP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    up_pulse |=> !up_pulse); // R6
  AST_DN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    dn_pulse |=> !dn_pulse); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!up_pulse && !dn_pulse) |=> $stable(pos)); // R9

endmodule

bind step_ctrl step_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .up_pulse(up_pulse), .dn_pulse(dn_pulse), .pos(pos)
);

// File: tb/step_ctrl_tb.sv
module step_ctrl_tb;
  localparam int DEB = 16;
  localparam int SETTLE = DEB + 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_btn = 1'b0;
  logic dn_btn = 1'b0;
  logic [1:0] pos;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  step_ctrl #(.DEB_CYCLES(DEB)) u_dut (
    .clk(clk), .rst(rst), .up_btn(up_btn), .dn_btn(dn_btn), .pos(pos)
  );

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(pos) != exp) begin
      errors++;
      $display("FAIL %s pos=%0d expected=%0d", req, pos, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; up_btn = 1'b0; dn_btn = 1'b0;
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_btn(input logic u, input logic d);
    up_btn = u; dn_btn = d;
    cycles(SETTLE);
  endtask

  task automatic goto_pos(input int p);
    do_reset();
    for (int i = 0; i < p; i++) begin
      set_btn(1'b1, 1'b0);
      set_btn(1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 reset", 0);
    cycles(50);
    check("R1 idle after reset", 0);

    for (int p = 0; p < 4; p++) begin
      for (int op = 0; op < 3; op++) begin
        int exp;
        goto_pos(p);
        check("R2 setup", p);
        if (op == 0) begin
          exp = (p < 3) ? p + 1 : 3;
          set_btn(1'b1, 1'b0);
          check(p == 3 ? "R4 up at top" : "R2 up step", exp);
        end else if (op == 1) begin
          exp = (p > 0) ? p - 1 : 0;
          set_btn(1'b0, 1'b1);
          check(p == 0 ? "R4 down at bottom" : "R3 down step", exp);
        end else begin
          exp = (p < 3) ? p + 1 : 3;
          set_btn(1'b1, 1'b1);
          check("R5 both at once", exp);
        end
        set_btn(1'b0, 1'b0);
        check("R6 release no step", exp);
      end
    end

    do_reset();
    up_btn = 1'b1;
    cycles(DEB * 20);
    check("R6 long hold", 1);
    set_btn(1'b0, 1'b0);

    up_btn = 1'b1;
    cycles(DEB - 1);
    up_btn = 1'b0;
    cycles(SETTLE);
    check("R7 short glitch rejected", 1);
    up_btn = 1'b1;
    cycles(DEB);
    up_btn = 1'b0;
    cycles(SETTLE);
    check("R7 full length accepted", 2);

    goto_pos(1);
    @(negedge clk);
    up_btn = 1'b1;
    cycles(DEB + 2);
    check("R8 before latency", 1);
    cycles(1);
    check("R8 at latency", 2);
    set_btn(1'b0, 1'b0);

    goto_pos(1);
    set_btn(1'b1, 1'b0);
    check("R9 up pressed", 2);
    set_btn(1'b1, 1'b1);
    check("R9 down pressed", 1);
    set_btn(1'b0, 1'b1);
    check("R9 up released", 1);
    set_btn(1'b1, 1'b1);
    check("R9 up again", 2);
    set_btn(1'b1, 1'b0);
    check("R9 down released", 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule